// File: doc/BRIEF.md
# Phase-Accumulator PWM Generator with Deferred Settings Update

This block drives one pulse-width-modulated output from a single 32-bit control word. Each clock a programmable step is added to a wrapping accumulator, so the output frequency is a fraction of the input clock set by that step. The top byte of the accumulator is compared with an 8-bit threshold to set the high time.

Software programs the step and threshold into a staged copy of the settings. The running output does not see them until software raises a request flag. The hardware then copies the staged settings into the running copy at the next output-cycle boundary and drops the flag by itself. Software polls the flag to learn when the change has taken effect. The enable bit acts at once and is separate from this request, so the output can be turned on either before or after a pending change completes.

Top module: `pwm_acc_top`

## Requirements
- R1: After synchronous reset, `rd_data` reads zero and `pwm_out` is low.
- R2: The control word layout is: bit 31 enable, bit 30 request flag (live), bits 29:8 step, bits 7:0 threshold. Only the low BASE_BITS of the step field are stored, and step bits at or above BASE_BITS read back as zero. Reads show the staged step and threshold.
- R3: While enabled, the BASE_BITS-wide accumulator adds the running step every clock, modulo 2^BASE_BITS. `pwm_out` is high exactly when the top 8 accumulator bits are greater than or equal to the running threshold. While disabled, `pwm_out` is low and the accumulator is held at zero.
- R4: A threshold of 0 keeps the output high on every enabled clock. A threshold above every top-byte value the step can reach keeps it low.
- R5: A write with bit 30 clear and no request pending replaces the staged fields and the enable, and leaves the running step and threshold unchanged.
- R6: A write with bit 30 set and no request pending raises the flag. At the next cycle boundary the running settings take the staged values, and the flag clears in that same clock.
- R7: A cycle boundary is a clock in which the accumulator wraps past zero, the output is disabled, or the running step is zero. A request made while disabled therefore completes on the following clock.
- R8: While the flag is set, a write changes only the enable. Its step, threshold and bit 30 are ignored.
- R9: Enabling before the request completes and enabling after it completes give the same steady output for the same settings.
- R10: For a step of 2^k, the output period is 2^(BASE_BITS-k) clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Enable, live request flag, staged step and threshold |
| pwm_out | output | 1 | Modulated output |

## Verification
A bad accumulator value or a bad running threshold shows at `pwm_out` within one output cycle. It appears as a wrong high count or a wrong edge spacing, which the cycle-accurate model compares on every clock. Corrupt staged fields or a stuck request flag show at `rd_data` on the very next clock. A flag that never clears shows up as a poll that exceeds one output period. A transfer taken at the wrong moment, or a write accepted while a request is pending, changes the high count of the following cycle.

// File: rtl/pwm_acc_pkg.sv
package pwm_acc_pkg;

    localparam int CTRL_W       = 32;
    localparam int DIV_W        = 8;
    localparam int STEP_FIELD_W = 22;

    // Control word as seen on the write and read paths.
    typedef struct packed {
        logic                    enable;
        logic                    request;
        logic [STEP_FIELD_W-1:0] step;
        logic [DIV_W-1:0]        thresh;
    } ctrl_word_t;

    // One set of waveform settings (staged or running).
    typedef struct packed {
        logic [STEP_FIELD_W-1:0] step;
        logic [DIV_W-1:0]        thresh;
    } wave_cfg_t;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_ALL,
        WR_ENABLE_ONLY
    } wr_kind_t;

    // Keep only the step bits the accumulator can use.
    function automatic logic [STEP_FIELD_W-1:0] trim_step(
        input logic [STEP_FIELD_W-1:0] raw,
        input int unsigned             keep
    );
        logic [STEP_FIELD_W-1:0] mask;
        mask = (STEP_FIELD_W'(1) << keep) - STEP_FIELD_W'(1);
        return raw & mask;
    endfunction

    function automatic logic [CTRL_W-1:0] status_word(
        input logic      en,
        input logic      req,
        input wave_cfg_t cfg
    );
        ctrl_word_t w;
        w.enable  = en;
        w.request = req;
        w.step    = cfg.step;
        w.thresh  = cfg.thresh;
        return w;
    endfunction

endpackage

// File: rtl/pwm_ctrl_regs.sv
module pwm_ctrl_regs
    import pwm_acc_pkg::*;
#(
    parameter int BASE_BITS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              cycle_start,
    output logic              enable,
    output logic              request,
    output wave_cfg_t         staged_cfg,
    output wave_cfg_t         running_cfg
);

    ctrl_word_t wr_word;
    wave_cfg_t  wr_cfg;
    wr_kind_t   wr_kind;

    always_comb begin
        wr_word       = ctrl_word_t'(wr_data);
        wr_cfg.step   = trim_step(wr_word.step, BASE_BITS);
        wr_cfg.thresh = wr_word.thresh;
        if (!wr_en) begin
            wr_kind = WR_IDLE;
        end else if (request) begin
            wr_kind = WR_ENABLE_ONLY;
        end else begin
            wr_kind = WR_ALL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable      <= 1'b0;
            request     <= 1'b0;
            staged_cfg  <= '0;
            running_cfg <= '0;
        end else begin
            if (request && cycle_start) begin
                running_cfg <= staged_cfg;
                request     <= 1'b0;
            end
            case (wr_kind)
                WR_ALL: begin
                    staged_cfg <= wr_cfg;
                    enable     <= wr_word.enable;
                    request    <= wr_word.request;
                end
                WR_ENABLE_ONLY: begin
                    enable <= wr_word.enable;
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/pwm_phase_acc.sv
module pwm_phase_acc
    import pwm_acc_pkg::*;
#(
    parameter int BASE_BITS = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    enable,
    input  logic [STEP_FIELD_W-1:0] step,
    output logic [BASE_BITS-1:0]    acc,
    output logic                    cycle_start
);

    localparam int SUM_W = STEP_FIELD_W + 1;

    logic [SUM_W-1:0] sum;
    logic             wrap;

    always_comb begin
        sum         = SUM_W'(acc) + SUM_W'(step);
        wrap        = |sum[SUM_W-1:BASE_BITS];
        cycle_start = !enable || (step == '0) || wrap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (!enable) begin
            acc <= '0;
        end else begin
            acc <= sum[BASE_BITS-1:0];
        end
    end

endmodule

// File: rtl/pwm_duty_cmp.sv
module pwm_duty_cmp
    import pwm_acc_pkg::*;
#(
    parameter int BASE_BITS = 16
) (
    input  logic                 enable,
    input  logic [BASE_BITS-1:0] acc,
    input  logic [DIV_W-1:0]     thresh,
    output logic                 pwm
);

    localparam int SHIFT = BASE_BITS - DIV_W;

    logic at_or_above;

    generate
        if (SHIFT == 0) begin : g_direct
            assign at_or_above = (acc >= thresh);
        end else begin : g_shifted
            logic [BASE_BITS-1:0] top;
            assign top         = acc >> SHIFT;
            assign at_or_above = (top >= BASE_BITS'(thresh));
        end
    endgenerate

    assign pwm = enable & at_or_above;

endmodule

// File: rtl/pwm_acc_top.sv
module pwm_acc_top
    import pwm_acc_pkg::*;
#(
    parameter int BASE_BITS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    output logic              pwm_out
);

    logic                    en_q;
    logic                    req_q;
    wave_cfg_t               stg_cfg;
    wave_cfg_t               run_cfg;
    logic [BASE_BITS-1:0]    acc_q;
    logic                    cyc_start;
    logic [STEP_FIELD_W-1:0] run_step;
    logic [DIV_W-1:0]        run_thresh;

    assign run_step   = run_cfg.step;
    assign run_thresh = run_cfg.thresh;

    pwm_ctrl_regs #(.BASE_BITS(BASE_BITS)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .cycle_start (cyc_start),
        .enable      (en_q),
        .request     (req_q),
        .staged_cfg  (stg_cfg),
        .running_cfg (run_cfg)
    );

    pwm_phase_acc #(.BASE_BITS(BASE_BITS)) u_acc (
        .clk         (clk),
        .rst         (rst),
        .enable      (en_q),
        .step        (run_step),
        .acc         (acc_q),
        .cycle_start (cyc_start)
    );

    pwm_duty_cmp #(.BASE_BITS(BASE_BITS)) u_cmp (
        .enable (en_q),
        .acc    (acc_q),
        .thresh (run_thresh),
        .pwm    (pwm_out)
    );

    assign rd_data = status_word(en_q, req_q, stg_cfg);

endmodule

// File: rtl/pwm_acc_checker.sv
module pwm_acc_checker
    import pwm_acc_pkg::*;
#(
    parameter int BASE_BITS = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic [CTRL_W-1:0]       rd_data,
    input logic                    pwm_out,
    input logic [BASE_BITS-1:0]    acc_q,
    input logic [STEP_FIELD_W-1:0] run_step,
    input logic [DIV_W-1:0]        run_thresh
);

    logic seen_rst = 1'b0;
    logic past_ok  = 1'b0;

    always_ff @(posedge clk) begin
        seen_rst <= seen_rst | rst;
        past_ok  <= seen_rst;
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        (past_ok && $past(rst)) |-> (rd_data == '0 && !pwm_out));

    assert_off_is_low_R3: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !rd_data[31]) |-> !pwm_out);

    assert_off_holds_acc_R3: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(rst) && !$past(rd_data[31])) |-> (acc_q == '0));

    assert_running_needs_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(rst) && !$past(rd_data[30]))
        |-> (run_step == $past(run_step) && run_thresh == $past(run_thresh)));

    assert_flag_fall_loads_R6: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(rst) && $fell(rd_data[30]))
        |-> (run_step == rd_data[29:8] && run_thresh == rd_data[7:0]));

    assert_pending_locks_fields_R8: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(rst) && $past(rd_data[30]))
        |-> (rd_data[29:0] == $past(rd_data[29:0])));

endmodule

bind pwm_acc_top pwm_acc_checker #(.BASE_BITS(BASE_BITS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_data    (rd_data),
    .pwm_out    (pwm_out),
    .acc_q      (acc_q),
    .run_step   (run_step),
    .run_thresh (run_thresh)
);

// File: tb/pwm_acc_top_tb.sv
module pwm_acc_top_tb;

    localparam int BB  = 16;
    localparam int MOD = 1 << BB;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pwm_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    pwm_acc_top #(.BASE_BITS(BB)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .pwm_out (pwm_out)
    );

    // Behavioural reference model, updated at each rising edge.
    int m_en, m_req, m_sstep, m_sthr, m_rstep, m_rthr, m_acc;

    always @(posedge clk) begin
        int n_acc, n_req;
        bit bnd;
        if (rst) begin
            m_en = 0; m_req = 0; m_sstep = 0; m_sthr = 0;
            m_rstep = 0; m_rthr = 0; m_acc = 0;
        end else begin
            bnd   = (m_en == 0) || (m_rstep == 0) || ((m_acc + m_rstep) >= MOD);
            n_acc = (m_en != 0) ? ((m_acc + m_rstep) % MOD) : 0;
            n_req = m_req;
            if (m_req != 0 && bnd) begin
                m_rstep = m_sstep;
                m_rthr  = m_sthr;
                n_req   = 0;
            end
            if (wr_en) begin
                if (m_req == 0) begin
                    m_sstep = int'(wr_data[29:8]) % MOD;
                    m_sthr  = int'(wr_data[7:0]);
                    m_en    = int'(wr_data[31]);
                    n_req   = int'(wr_data[30]);
                end else begin
                    m_en = int'(wr_data[31]);
                end
            end
            m_acc = n_acc;
            m_req = n_req;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Clock-by-clock comparison against the model (R2, R3).
    always @(negedge clk) begin
        logic [31:0] exp_rd;
        logic        exp_out;
        if (!rst) begin
            exp_rd  = {m_en[0], m_req[0], 22'(m_sstep), 8'(m_sthr)};
            exp_out = (m_en != 0) && ((m_acc >> (BB - 8)) >= m_rthr);
            chk("R3", "pwm_out vs model", {31'b0, pwm_out}, {31'b0, exp_out});
            chk("R2", "rd_data vs model", rd_data, exp_rd);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] mk(input logic en, input logic rq,
                                       input logic [21:0] step, input logic [7:0] thr);
        return {en, rq, step, thr};
    endfunction

    // Called at a falling edge; the write is taken at the next rising edge.
    task automatic wr(input logic [31:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic count_high(input int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            h += int'(pwm_out);
            @(negedge clk);
        end
    endtask

    task automatic wait_clear(output int n);
        n = 0;
        while (rd_data[30] && n < 100) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int h, n;
        logic prev;
        repeat (3) @(negedge clk);
        chk("R1", "rd_data in reset", rd_data, 32'h0);
        chk("R1", "pwm_out in reset", {31'b0, pwm_out}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "rd_data after reset", rd_data, 32'h0);

        // R2: step bits above BASE_BITS are dropped
        wr(mk(1'b0, 1'b0, 22'h3F_1000, 8'h80));
        chk("R2", "staged readback", rd_data, mk(1'b0, 1'b0, 22'h00_1000, 8'h80));

        // R7: request while disabled completes one clock later
        wr(mk(1'b0, 1'b1, 22'h1000, 8'h80));
        chk("R7", "flag raised", {31'b0, rd_data[30]}, 32'h1);
        @(negedge clk);
        chk("R7", "flag cleared while disabled", {31'b0, rd_data[30]}, 32'h0);

        // R3: enabled, step 0x1000, threshold 0x80 -> 8 of 16 high
        wr(mk(1'b1, 1'b0, 22'h1000, 8'h80));
        count_high(32, h);
        chk("R3", "high count half duty", h, 16);

        // R10: rising edges 16 clocks apart
        prev = pwm_out;
        n = 0;
        while (!(pwm_out && !prev) && n < 40) begin prev = pwm_out; @(negedge clk); n++; end
        n = 0;
        prev = pwm_out;
        @(negedge clk);
        n = 1;
        while (!(pwm_out && !prev) && n < 40) begin prev = pwm_out; @(negedge clk); n++; end
        chk("R10", "period in clocks", n, 16);

        // R5: staged write alone leaves the running threshold
        wr(mk(1'b1, 1'b0, 22'h1000, 8'h00));
        chk("R5", "staged threshold readback", {24'b0, rd_data[7:0]}, 32'h0);
        count_high(32, h);
        chk("R5", "high count unchanged", h, 16);

        // R6: request while running clears within one output cycle
        wr(mk(1'b1, 1'b1, 22'h1000, 8'h00));
        chk("R6", "flag raised while running", {31'b0, rd_data[30]}, 32'h1);
        wait_clear(n);
        chk("R6", "flag cleared within a cycle", {31'b0, n <= 16}, 32'h1);
        count_high(32, h);
        chk("R4", "threshold 0 always high", h, 32);

        // R8: second write during a pending request is ignored
        wr(mk(1'b1, 1'b1, 22'h2000, 8'hFF));
        wr(mk(1'b1, 1'b1, 22'h0400, 8'h40));
        chk("R8", "fields locked while pending", {2'b0, rd_data[29:0]},
            {2'b0, mk(1'b0, 1'b0, 22'h2000, 8'hFF)});
        wait_clear(n);
        count_high(32, h);
        chk("R4", "threshold 0xFF never high", h, 0);

        // R8: enable still accepted while pending
        wr(mk(1'b1, 1'b1, 22'h1000, 8'h80));
        wr(mk(1'b0, 1'b0, 22'h0400, 8'h40));
        chk("R8", "enable taken while pending", {31'b0, rd_data[31]}, 32'h0);
        chk("R8", "fields kept while pending", {2'b0, rd_data[29:0]},
            {2'b0, mk(1'b0, 1'b0, 22'h1000, 8'h80)});
        chk("R8", "output low after disable", {31'b0, pwm_out}, 32'h0);
        wait_clear(n);

        // R9 order A: update completes, then enable
        wr(mk(1'b0, 1'b0, 22'h1000, 8'h40));
        wr(mk(1'b0, 1'b1, 22'h1000, 8'h40));
        wait_clear(n);
        wr(mk(1'b1, 1'b0, 22'h1000, 8'h40));
        count_high(32, h);
        chk("R9", "enable after update", h, 24);

        // load a different running config, disabled
        wr(mk(1'b0, 1'b0, 22'h2000, 8'hFF));
        wr(mk(1'b0, 1'b1, 22'h2000, 8'hFF));
        wait_clear(n);

        // R9 order B: enable while the request is pending
        wr(mk(1'b0, 1'b0, 22'h1000, 8'h40));
        wr(mk(1'b0, 1'b1, 22'h1000, 8'h40));
        wr(mk(1'b1, 1'b1, 22'h1000, 8'h40));
        wait_clear(n);
        count_high(32, h);
        chk("R9", "enable before update", h, 24);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule